// File: doc/BRIEF.md
# Same-Slice Coincidence Pair Former

This block collects singles event words from a set of detector-unit inputs and turns them into coincidence event words. Time is cut into fixed slices. On the clock where the slice strobes are high, the block captures up to four qualified words from each unit. It then emits one coincidence word for every pairing of two captured words that belong to different units. Timing is judged only by slice membership: any two words captured in the same slice from different units form a coincidence. With eight units there are 28 unit pairings. Each pairing can give sixteen candidates, so one slice can produce up to 448 candidates.

Candidates leave on a valid/ready stream, one per clock while the consumer is ready. They come out in a fixed order. The outer order is the unit pairing (lower unit, then higher unit, both ascending). Within a pairing, the order is the word index of the lower unit and then the word index of the higher unit. A new slice replaces whatever is still waiting. Each discarded candidate is added to a saturating lost counter.

A bypass mode, chosen per slice, forwards the captured singles unchanged instead of pairing them. The block is built around a two-state emitter. ST_IDLE means nothing is pending. ST_EMIT means at least one word is pending. The transitions are as follows:
- A strobe that captures at least one candidate moves to ST_EMIT.
- A strobe that captures none moves to ST_IDLE.
- Accepting the last pending word moves from ST_EMIT to ST_IDLE.
- A strobe while in ST_EMIT stays in ST_EMIT with a fresh candidate set, provided the new slice has candidates.

Top module: `coinc_pair_former`

## Requirements
- R1: When any bit of `in_slice` is high at a rising edge, the block captures all qualified words and the bypass selection. The first resulting output word is presented in the cycle after that edge.
- R2: In pairing mode, every qualified word of unit i is paired with every qualified word of unit j, for every i < j. No word is paired with a word of its own unit. `out_unit_a`/`out_payload_a` carry the lower unit and its word, and `out_unit_b`/`out_payload_b` carry the higher unit and its word. `out_is_pair` is 1.
- R3: Pairing-mode output order is ascending by (lower unit, higher unit), then by the lower unit's word index, then by the higher unit's word index.
- R4: While `out_ready` is held high, pending words leave one per clock with no gaps.
- R5: While `out_valid` is high and `out_ready` is low, and no strobe occurs, the presented word stays unchanged and is not lost.
- R6: At a strobe, every pending word not accepted in that same cycle is discarded and added to `lost_count`. A word accepted in the strobe cycle counts as delivered.
- R7: `lost_count` saturates at its all-ones value and never decreases except at reset.
- R8: In bypass mode, each qualified word is emitted once with `out_is_pair` = 0, `out_unit_a` = its unit, `out_payload_a` = the word, and `out_unit_b` and `out_payload_b` = 0. Words come out in unit order, then word order, under the same discard rule.
- R9: After reset, `out_valid` is 0 and `lost_count` is 0.
- R10: A slice whose qualified words all come from one unit (pairing mode) produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Bypass selection, sampled at the strobe |
| in_slice | input | N_UNITS | Per-unit slice strobes, asserted together |
| in_valid | input | N_UNITS*N_WORDS | Word qualifiers, bit u*N_WORDS+w |
| in_data | input | N_UNITS*N_WORDS*PAY_W | Word payloads, slot u*N_WORDS+w at bits slot*PAY_W upward |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Output word present |
| out_is_pair | output | 1 | 1 for a coincidence, 0 for a bypassed single |
| out_unit_a | output | clog2(N_UNITS) | Lower unit (or source unit in bypass) |
| out_unit_b | output | clog2(N_UNITS) | Higher unit (0 in bypass) |
| out_payload_a | output | PAY_W | Payload of the lower unit's word |
| out_payload_b | output | PAY_W | Payload of the higher unit's word (0 in bypass) |
| lost_count | output | LOST_W | Saturating count of discarded words |

## Verification
The properties assume that the per-unit slice strobes always arrive together, either all high or all low. The checker also asserts this as an input rule, and the stimulus only ever drives all strobes together. The stability property further takes for granted that the consumer does not need the word to persist across a new strobe. The bench honours this by comparing against a model that replaces its queue at every strobe. The stimulus varies the ready pattern, the set of units that carry words, and the gap between strobes. Some gaps are short, so that discards occur both with ready high and with ready low in the strobe cycle.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_EMIT
    } emit_state_e;

    function automatic int pair_total(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // Rank of unit pairing (lo, hi), lo < hi, in ascending lexicographic order
    function automatic int pair_slot(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

    function automatic int pair_lo(input int p, input int n);
        int r;
        r = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++)
                if (pair_slot(i, j, n) == p) r = i;
        return r;
    endfunction

    function automatic int pair_hi(input int p, input int n);
        int r;
        r = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++)
                if (pair_slot(i, j, n) == p) r = j;
        return r;
    endfunction

endpackage

// File: rtl/coinc_snapshot.sv
module coinc_snapshot #(
    parameter int N_SLOTS = 32,
    parameter int PAY_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       mode_in,
    input  logic [N_SLOTS*PAY_W-1:0]   data_in,
    output logic                       mode_q,
    output logic [N_SLOTS*PAY_W-1:0]   data_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (load)
            mode_q <= mode_in;
    end

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[k*PAY_W +: PAY_W] <= '0;
            else if (load)
                data_q[k*PAY_W +: PAY_W] <= data_in[k*PAY_W +: PAY_W];
        end
    end

endmodule

// File: rtl/coinc_cand_gen.sv
module coinc_cand_gen
    import coinc_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int N_WORDS = 4,
    parameter int N_CAND  = 448
) (
    input  logic                         bypass,
    input  logic [N_UNITS*N_WORDS-1:0]   valid,
    output logic [N_CAND-1:0]            cand
);

    localparam int SQ = N_WORDS * N_WORDS;

    logic [N_CAND-1:0] pair_vec;
    logic [N_CAND-1:0] single_vec;

    always_comb begin
        pair_vec = '0;
        for (int i = 0; i < N_UNITS; i++)
            for (int j = i + 1; j < N_UNITS; j++)
                for (int a = 0; a < N_WORDS; a++)
                    for (int b = 0; b < N_WORDS; b++)
                        pair_vec[pair_slot(i, j, N_UNITS) * SQ + a * N_WORDS + b] =
                            valid[i * N_WORDS + a] & valid[j * N_WORDS + b];
    end

    always_comb begin
        single_vec = '0;
        single_vec[N_UNITS*N_WORDS-1:0] = valid;
    end

    assign cand = bypass ? single_vec : pair_vec;

endmodule

// File: rtl/coinc_first_pick.sv
module coinc_first_pick #(
    parameter int N_CAND = 448,
    parameter int IDX_W  = 9,
    parameter int CNT_W  = 9
) (
    input  logic [N_CAND-1:0] vec,
    output logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  count
);

    always_comb begin
        idx = '0;
        for (int k = N_CAND - 1; k >= 0; k--)
            if (vec[k]) idx = IDX_W'(k);
    end

    always_comb begin
        count = '0;
        for (int k = 0; k < N_CAND; k++)
            count = count + CNT_W'(vec[k]);
    end

endmodule

// File: rtl/coinc_pair_former.sv
module coinc_pair_former
    import coinc_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int N_WORDS = 4,
    parameter int PAY_W   = 32,
    parameter int LOST_W  = 16,
    localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bypass_en,
    input  logic [N_UNITS-1:0]                 in_slice,
    input  logic [N_UNITS*N_WORDS-1:0]         in_valid,
    input  logic [N_UNITS*N_WORDS*PAY_W-1:0]   in_data,
    input  logic                               out_ready,
    output logic                               out_valid,
    output logic                               out_is_pair,
    output logic [UNIT_W-1:0]                  out_unit_a,
    output logic [UNIT_W-1:0]                  out_unit_b,
    output logic [PAY_W-1:0]                   out_payload_a,
    output logic [PAY_W-1:0]                   out_payload_b,
    output logic [LOST_W-1:0]                  lost_count
);

    localparam int N_SINGLE = N_UNITS * N_WORDS;
    localparam int SQ       = N_WORDS * N_WORDS;
    localparam int N_PAIRC  = pair_total(N_UNITS) * SQ;
    localparam int N_CAND   = (N_PAIRC > N_SINGLE) ? N_PAIRC : N_SINGLE;
    localparam int IDX_W    = (N_CAND > 1) ? $clog2(N_CAND) : 1;
    localparam int CNT_W    = $clog2(N_CAND + 1);
    localparam int SUM_W    = ((LOST_W > CNT_W) ? LOST_W : CNT_W) + 1;

    emit_state_e state_q, state_d;

    logic                        slice_go;
    logic                        fire;
    logic                        mode_q;
    logic [N_SINGLE*PAY_W-1:0]   data_q;
    logic [N_CAND-1:0]           cand_new;
    logic [N_CAND-1:0]           pending_q;
    logic [IDX_W-1:0]            pick_idx;
    logic [CNT_W-1:0]            pick_cnt;
    logic [CNT_W-1:0]            drop_cnt;
    logic [SUM_W-1:0]            lost_sum;
    logic [LOST_W-1:0]           lost_q;

    assign slice_go = |in_slice;
    assign fire     = out_valid & out_ready;

    coinc_snapshot #(
        .N_SLOTS (N_SINGLE),
        .PAY_W   (PAY_W)
    ) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slice_go),
        .mode_in (bypass_en),
        .data_in (in_data),
        .mode_q  (mode_q),
        .data_q  (data_q)
    );

    coinc_cand_gen #(
        .N_UNITS (N_UNITS),
        .N_WORDS (N_WORDS),
        .N_CAND  (N_CAND)
    ) u_cand (
        .bypass (bypass_en),
        .valid  (in_valid),
        .cand   (cand_new)
    );

    coinc_first_pick #(
        .N_CAND (N_CAND),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .vec   (pending_q),
        .idx   (pick_idx),
        .count (pick_cnt)
    );

    // Pending candidate set: replaced at a strobe, one bit cleared per accept
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= '0;
        else if (slice_go)
            pending_q <= cand_new;
        else if (fire)
            pending_q <= pending_q & ~(N_CAND'(1) << pick_idx);
    end

    // Discard accounting
    assign drop_cnt = pick_cnt - CNT_W'(fire);
    assign lost_sum = SUM_W'(lost_q) + SUM_W'(drop_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n)
            lost_q <= '0;
        else if (slice_go) begin
            if (lost_sum > SUM_W'({LOST_W{1'b1}}))
                lost_q <= {LOST_W{1'b1}};
            else
                lost_q <= lost_sum[LOST_W-1:0];
        end
    end

    assign lost_count = lost_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (slice_go)
            state_d = (|cand_new) ? ST_EMIT : ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_EMIT: if (fire && pick_cnt == CNT_W'(1)) state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: decode the lowest pending candidate
    always_comb begin
        int sel;
        int p;
        int wa;
        int wb;
        int lo;
        int hi;
        out_valid     = 1'b0;
        out_is_pair   = 1'b0;
        out_unit_a    = '0;
        out_unit_b    = '0;
        out_payload_a = '0;
        out_payload_b = '0;
        sel = int'(pick_idx);
        p   = sel / SQ;
        wa  = (sel / N_WORDS) % N_WORDS;
        wb  = sel % N_WORDS;
        lo  = pair_lo(p, N_UNITS);
        hi  = pair_hi(p, N_UNITS);
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                if (mode_q) begin
                    out_unit_a    = UNIT_W'((sel % N_SINGLE) / N_WORDS);
                    out_payload_a = data_q[(sel % N_SINGLE) * PAY_W +: PAY_W];
                end else begin
                    out_is_pair   = 1'b1;
                    out_unit_a    = UNIT_W'(lo);
                    out_unit_b    = UNIT_W'(hi);
                    out_payload_a = data_q[(lo * N_WORDS + wa) * PAY_W +: PAY_W];
                    out_payload_b = data_q[(hi * N_WORDS + wb) * PAY_W +: PAY_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/coinc_pair_former_chk.sv
module coinc_pair_former_chk #(
    parameter int N_UNITS = 8,
    parameter int PAY_W   = 32,
    parameter int LOST_W  = 16,
    parameter int UNIT_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_UNITS-1:0]  in_slice,
    input logic                out_ready,
    input logic                out_valid,
    input logic                out_is_pair,
    input logic [UNIT_W-1:0]   out_unit_a,
    input logic [UNIT_W-1:0]   out_unit_b,
    input logic [PAY_W-1:0]    out_payload_a,
    input logic [PAY_W-1:0]    out_payload_b,
    input logic [LOST_W-1:0]   lost_count
);

    logic go;
    assign go = |in_slice;

    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slice == '0) || (&in_slice)); // R1

    AST_NO_OUTPUT_WITHOUT_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !out_valid) |=> !out_valid); // R1

    AST_PAIR_UNITS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_pair) |-> (out_unit_a < out_unit_b)); // R2

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !go) |=>
            (out_valid && $stable(out_is_pair) && $stable(out_unit_a) && $stable(out_unit_b)
             && $stable(out_payload_a) && $stable(out_payload_b))); // R5

    AST_LOST_ONLY_AT_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(lost_count)); // R6

    AST_LOST_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (lost_count >= $past(lost_count))); // R7

    AST_BYPASS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_pair) |-> (out_unit_b == '0 && out_payload_b == '0)); // R8

endmodule

bind coinc_pair_former coinc_pair_former_chk #(
    .N_UNITS (N_UNITS),
    .PAY_W   (PAY_W),
    .LOST_W  (LOST_W),
    .UNIT_W  (UNIT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_slice      (in_slice),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_is_pair   (out_is_pair),
    .out_unit_a    (out_unit_a),
    .out_unit_b    (out_unit_b),
    .out_payload_a (out_payload_a),
    .out_payload_b (out_payload_b),
    .lost_count    (lost_count)
);

// File: tb/coinc_pair_former_tb.sv
module coinc_pair_former_tb;

    localparam int NU = 8;
    localparam int NW = 4;
    localparam int PW = 32;
    localparam int LW = 6;
    localparam int LMAX = 63;

    typedef struct packed {
        logic          pair;
        logic [2:0]    ua;
        logic [2:0]    ub;
        logic [PW-1:0] pa;
        logic [PW-1:0] pb;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bypass_en = 1'b0;
    logic [NU-1:0]         in_slice = '0;
    logic [NU*NW-1:0]      in_valid = '0;
    logic [NU*NW*PW-1:0]   in_data = '0;
    logic                  out_ready = 1'b0;
    logic                  out_valid;
    logic                  out_is_pair;
    logic [2:0]            out_unit_a;
    logic [2:0]            out_unit_b;
    logic [PW-1:0]         out_payload_a;
    logic [PW-1:0]         out_payload_b;
    logic [LW-1:0]         lost_count;

    always #2.5 clk = ~clk;

    coinc_pair_former #(
        .N_UNITS (NU),
        .N_WORDS (NW),
        .PAY_W   (PW),
        .LOST_W  (LW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bypass_en     (bypass_en),
        .in_slice      (in_slice),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .out_ready     (out_ready),
        .out_valid     (out_valid),
        .out_is_pair   (out_is_pair),
        .out_unit_a    (out_unit_a),
        .out_unit_b    (out_unit_b),
        .out_payload_a (out_payload_a),
        .out_payload_b (out_payload_b),
        .lost_count    (lost_count)
    );

    int          checks = 0;
    int          fails = 0;
    int          model_lost = 0;
    exp_t        q[$];
    logic [PW-1:0] wd [NU][NW];
    logic          vl [NU][NW];

    task automatic clear_words();
        for (int u = 0; u < NU; u++)
            for (int w = 0; w < NW; w++) begin
                vl[u][w] = 1'b0;
                wd[u][w] = 32'hC0DE_0000 + 32'(u * 16 + w);
            end
    endtask

    task automatic build(input logic byp);
        q.delete();
        if (byp) begin
            for (int u = 0; u < NU; u++)
                for (int w = 0; w < NW; w++)
                    if (vl[u][w]) q.push_back({1'b0, 3'(u), 3'd0, wd[u][w], 32'd0});
        end else begin
            for (int i = 0; i < NU; i++)
                for (int j = i + 1; j < NU; j++)
                    for (int a = 0; a < NW; a++)
                        for (int b = 0; b < NW; b++)
                            if (vl[i][a] && vl[j][b])
                                q.push_back({1'b1, 3'(i), 3'(j), wd[i][a], wd[j][b]});
        end
    endtask

    task automatic tick(input string tag, input logic strobe, input logic byp, input logic rdy);
        exp_t e;
        int   fired;
        @(negedge clk);
        checks++;
        if (q.size() > 0) begin
            e = q[0];
            if (out_valid !== 1'b1 || out_is_pair !== e.pair || out_unit_a !== e.ua ||
                out_unit_b !== e.ub || out_payload_a !== e.pa || out_payload_b !== e.pb) begin
                fails++;
                $display("FAIL %s t=%0t actual v=%b p=%b a=%0d b=%0d pa=%h pb=%h expected v=1 p=%b a=%0d b=%0d pa=%h pb=%h",
                         tag, $time, out_valid, out_is_pair, out_unit_a, out_unit_b, out_payload_a,
                         out_payload_b, e.pair, e.ua, e.ub, e.pa, e.pb);
            end
        end else if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s t=%0t actual out_valid=%b expected out_valid=0", tag, $time, out_valid);
        end
        checks++;
        if (lost_count !== LW'(model_lost)) begin
            fails++;
            $display("FAIL %s t=%0t actual lost=%0d expected lost=%0d", tag, $time, lost_count, model_lost);
        end
        in_slice  = strobe ? '1 : '0;
        bypass_en = byp;
        out_ready = rdy;
        for (int u = 0; u < NU; u++)
            for (int w = 0; w < NW; w++) begin
                in_valid[u*NW + w] = vl[u][w];
                in_data[(u*NW + w)*PW +: PW] = wd[u][w];
            end
        if (rst_n) begin
            fired = (q.size() > 0 && rdy) ? 1 : 0;
            if (strobe) begin
                model_lost = model_lost + q.size() - fired;
                if (model_lost > LMAX) model_lost = LMAX;
                build(byp);
            end else if (fired == 1) begin
                void'(q.pop_front());
            end
        end
    endtask

    task automatic expect_lost(input string tag, input int val);
        @(negedge clk);
        checks++;
        if (lost_count !== LW'(val)) begin
            fails++;
            $display("FAIL %s actual lost=%0d expected lost=%0d", tag, lost_count, val);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_words();
        // R9: reset state
        repeat (3) tick("R9", 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        tick("R9", 1'b0, 1'b0, 1'b1);

        // R1 R2 R3 R4: sparse slice, ready held high
        clear_words();
        vl[0][0] = 1; vl[0][2] = 1; vl[3][1] = 1; vl[5][0] = 1; vl[5][1] = 1; vl[5][3] = 1;
        tick("R1", 1'b1, 1'b0, 1'b1);
        repeat (15) tick("R3", 1'b0, 1'b0, 1'b1);

        // R2 R5: two full units, stalling consumer
        clear_words();
        for (int w = 0; w < NW; w++) begin vl[1][w] = 1; vl[2][w] = 1; wd[2][w] = 32'h5A00_0000 + 32'(w); end
        tick("R2", 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 50; k++) tick("R5", 1'b0, 1'b0, (k % 3) == 0);

        // R10: one unit only
        clear_words();
        for (int w = 0; w < NW; w++) vl[4][w] = 1;
        tick("R10", 1'b1, 1'b0, 1'b1);
        repeat (5) tick("R10", 1'b0, 1'b0, 1'b1);

        // R6: discards, accept in strobe cycle counts as delivered
        clear_words();
        for (int w = 0; w < NW; w++) begin vl[1][w] = 1; vl[6][w] = 1; end
        tick("R6", 1'b1, 1'b0, 1'b1);
        repeat (5) tick("R6", 1'b0, 1'b0, 1'b1);
        tick("R6", 1'b1, 1'b0, 1'b1);
        repeat (3) tick("R6", 1'b0, 1'b0, 1'b0);
        tick("R6", 1'b1, 1'b0, 1'b0);
        repeat (20) tick("R6", 1'b0, 1'b0, 1'b1);
        expect_lost("R6", 26);

        // R8: bypass
        clear_words();
        vl[0][3] = 1; vl[2][0] = 1; vl[2][1] = 1; vl[7][2] = 1; vl[7][3] = 1;
        tick("R8", 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 10; k++) tick("R8", 1'b0, 1'b0, (k % 2) == 0);
        expect_lost("R8", 26);

        // R7: saturation with full slices
        clear_words();
        for (int u = 0; u < NU; u++) for (int w = 0; w < NW; w++) vl[u][w] = 1;
        tick("R7", 1'b1, 1'b0, 1'b1);
        repeat (2) tick("R7", 1'b0, 1'b0, 1'b1);
        tick("R7", 1'b1, 1'b0, 1'b1);
        repeat (2) tick("R7", 1'b0, 1'b0, 1'b1);
        tick("R7", 1'b1, 1'b0, 1'b1);
        repeat (460) tick("R4", 1'b0, 1'b0, 1'b1);
        expect_lost("R7", LMAX);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule